// File: doc/BRIEF.md
# CCD Electronic Shutter Sequencer

This block sets the exposure time of an interline CCD sensor. On each line it decides whether to fire the substrate discharge pulse, which empties the photodiodes. On each field boundary it decides whether the charge is transferred to the vertical registers (readout). The exposure length is set by a shutter mode, a field count and a line index.

The field count makes the exposure longer by whole vertical periods. The line index trims the final field: the substrate is swept on every line from the field start up to and including the selected line, and exposure runs from that last sweep to the next readout. A held mode suppresses readout for as long as it is applied, so a host can stretch the exposure by hand. While a multi-field exposure runs, the busy flag is high and new settings are not taken.

Settings are sampled at a vertical strobe only when no multi-field exposure is pending. They govern the field that begins at that strobe.

Top module: `ccd_shutter_seq`

## Requirements
- R1: After synchronous reset, sub_pulse_o, read_en_o, busy_o and err_o are all low. The applied mode is 00, so the first vertical strobe produces a readout.
- R2: With applied mode 01, in a field whose pending-field count is zero, a substrate pulse starts on line 0 (the vertical strobe) and on every horizontal strobe whose new line index is less than or equal to the applied line count. Line index n is the number of horizontal strobes since the vertical strobe.
- R3: Modes 00 and 10 issue no line-driven substrate pulse, read out on every field, and ignore the frame count (busy stays low).
- R4: With mode 01 and frame count F, the F vertical strobes after a readout produce no readout and no substrate pulse, and busy_o is high during those F fields. The next field has pulses and is read out at its end.
- R5: While busy_o is high, changes to the mode, frame, line and exposure inputs have no effect. The pending exposure completes with the settings that were applied.
- R6: Mode 11 ignores the frame and line inputs. A field governed by mode 11 produces no readout at its closing vertical strobe, and no line-driven pulse.
- R7: When the exposure bit is applied and a readout occurs at a vertical strobe, one substrate pulse starts on line 1, whatever the mode.
- R8: In mode 01, a line count above LINE_MAX is clamped to LINE_MAX and sets err_o, which then stays high until reset.
- R9: In monitoring drive (rec_mode_i=0) and mode 01, a line count below MON_MIN is clamped to MON_MIN and sets err_o. In recording drive, line counts from 0 up are legal.
- R10: read_en_o goes high on the cycle after a readout vertical strobe and stays high only until the next horizontal strobe, which marks line 0.
- R11: Every substrate pulse lasts exactly SUB_W clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync_i | input | 1 | One-cycle vertical strobe (field start, line 0) |
| hsync_i | input | 1 | One-cycle horizontal strobe (next line) |
| rec_mode_i | input | 1 | 0 = monitoring drive, 1 = recording drive |
| shut_mode_i | input | 2 | 00/10 off, 01 timed shutter, 11 readout hold |
| frame_cnt_i | input | 8 | Extra vertical periods of exposure |
| line_cnt_i | input | 10 | Last line swept by the substrate pulse |
| expose_i | input | 1 | Force one substrate pulse on the line after readout |
| sub_pulse_o | output | 1 | Substrate discharge pulse |
| read_en_o | output | 1 | Readout enable for the readout line |
| busy_o | output | 1 | Multi-field exposure pending; settings frozen |
| err_o | output | 1 | Sticky illegal line-count flag |

## Verification
A wrong pending-field count shows up within one field. Readout falls at the wrong vertical strobe, and busy_o disagrees with the count of fields since the last readout. A wrong line counter or clamp value moves the last substrate pulse by one or more lines inside the same field. A wrong applied-settings register shows at the first field after the change: pulses appear that should be absent, or the reverse. The bench sweeps every line count across the legal range and beyond it in both drive modes, and compares pulse widths and line positions for each field.

// File: rtl/shut_pkg.sv
package shut_pkg;

    localparam int LINE_W  = 10;
    localparam int FRAME_W = 8;

    typedef enum logic [1:0] {
        SM_OFF   = 2'b00,
        SM_TIMED = 2'b01,
        SM_OFF2  = 2'b10,
        SM_HOLD  = 2'b11
    } shut_mode_e;

    typedef struct packed {
        shut_mode_e mode;
        logic       expose;
    } shut_cfg_t;

    typedef struct packed {
        logic [LINE_W-1:0] val;
        logic              bad;
    } clamp_t;

    function automatic clamp_t clamp_lines(input logic [LINE_W-1:0] raw,
                                           input logic              rec,
                                           input logic [LINE_W-1:0] hi,
                                           input logic [LINE_W-1:0] lo);
        clamp_t r;
        r.val = raw;
        r.bad = 1'b0;
        if (raw > hi) begin
            r.val = hi;
            r.bad = 1'b1;
        end else if (!rec && raw < lo) begin
            r.val = lo;
            r.bad = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [LINE_W-1:0] sat_inc(input logic [LINE_W-1:0] v);
        return (v == '1) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/shut_line_ctr.sv
module shut_line_ctr
    import shut_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vsync_i,
    input  logic              hsync_i,
    output logic [LINE_W-1:0] line_nxt_o,
    output logic [LINE_W-1:0] line_q_o
);

    logic [LINE_W-1:0] line_q;

    always_comb begin
        line_nxt_o = line_q;
        if (vsync_i)      line_nxt_o = '0;
        else if (hsync_i) line_nxt_o = sat_inc(line_q);
    end

    always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= line_nxt_o;
    end

    assign line_q_o = line_q;

    // R2: a vertical strobe always restarts the line index at zero
    a_r2_line_restart: assert property (@(posedge clk) disable iff (rst)
        vsync_i |=> (line_q == '0));

endmodule

// File: rtl/shut_field_ctl.sv
module shut_field_ctl
    import shut_pkg::*;
#(
    parameter int LINE_MAX = 12'h20C,
    parameter int MON_MIN  = 12'h107
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               vsync_i,
    input  logic               rec_i,
    input  logic [1:0]         mode_i,
    input  logic [FRAME_W-1:0] frames_i,
    input  logic [LINE_W-1:0]  lines_i,
    input  logic               expose_i,
    output logic               read_go_o,
    output logic               timed_nxt_o,
    output logic               expose_nxt_o,
    output logic               final_nxt_o,
    output logic [LINE_W-1:0]  lc_nxt_o,
    output logic               hold_q_o,
    output logic               busy_o,
    output logic               err_o
);

    localparam logic [LINE_W-1:0] HI = LINE_W'(LINE_MAX);
    localparam logic [LINE_W-1:0] LO = LINE_W'(MON_MIN);

    shut_cfg_t          cfg_q, cfg_n;
    logic [FRAME_W-1:0] rem_q, rem_n;
    logic [LINE_W-1:0]  lc_q, lc_n;
    logic               err_q, err_n;
    clamp_t             cl;
    shut_mode_e         mode_in;

    assign mode_in = shut_mode_e'(mode_i);

    always_comb begin
        cl    = clamp_lines(lines_i, rec_i, HI, LO);
        cfg_n = cfg_q;
        rem_n = rem_q;
        lc_n  = lc_q;
        err_n = err_q;
        if (vsync_i) begin
            if (rem_q != '0) begin
                rem_n = rem_q - 1'b1;
            end else begin
                cfg_n.mode   = mode_in;
                cfg_n.expose = expose_i;
                lc_n         = cl.val;
                rem_n        = (mode_in == SM_TIMED) ? frames_i : '0;
                err_n        = err_q | ((mode_in == SM_TIMED) & cl.bad);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{mode: SM_OFF, expose: 1'b0};
            rem_q <= '0;
            lc_q  <= HI;
            err_q <= 1'b0;
        end else begin
            cfg_q <= cfg_n;
            rem_q <= rem_n;
            lc_q  <= lc_n;
            err_q <= err_n;
        end
    end

    assign read_go_o    = vsync_i && (rem_q == '0) && (cfg_q.mode != SM_HOLD);
    assign timed_nxt_o  = (cfg_n.mode == SM_TIMED);
    assign expose_nxt_o = cfg_n.expose;
    assign final_nxt_o  = (rem_n == '0);
    assign lc_nxt_o     = lc_n;
    assign hold_q_o     = (cfg_q.mode == SM_HOLD);
    assign busy_o       = (rem_q != '0);
    assign err_o        = err_q;

    // R4: each vertical strobe during a pending exposure consumes one field
    a_r4_field_countdown: assert property (@(posedge clk) disable iff (rst)
        (vsync_i && rem_q != '0) |=> (rem_q == $past(rem_q) - 1'b1));

    // R5: applied settings cannot move while fields remain
    a_r5_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (rem_q != '0) |=> ($stable(cfg_q) && $stable(lc_q)));

    // R8: the applied line count never leaves the legal range
    a_r8_lc_legal: assert property (@(posedge clk) disable iff (rst)
        lc_q <= HI);

    // R8: the error flag is sticky
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

endmodule

// File: rtl/shut_sub_gen.sv
module shut_sub_gen #(
    parameter int SUB_W = 4
)(
    input  logic clk,
    input  logic rst,
    input  logic fire_i,
    output logic sub_o
);

    localparam int CW = $clog2(SUB_W + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (fire_i)       cnt_q <= CW'(SUB_W);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign sub_o = (cnt_q != '0);

    // R11: a fired pulse is visible on the next cycle
    a_r11_fire_visible: assert property (@(posedge clk) disable iff (rst)
        fire_i |=> sub_o);

    // R11: the width counter never exceeds the programmed width
    a_r11_width_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(SUB_W));

endmodule

// File: rtl/ccd_shutter_seq.sv
module ccd_shutter_seq
    import shut_pkg::*;
#(
    parameter int LINE_MAX = 12'h20C,
    parameter int MON_MIN  = 12'h107,
    parameter int SUB_W    = 4
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               vsync_i,
    input  logic               hsync_i,
    input  logic               rec_mode_i,
    input  logic [1:0]         shut_mode_i,
    input  logic [FRAME_W-1:0] frame_cnt_i,
    input  logic [LINE_W-1:0]  line_cnt_i,
    input  logic               expose_i,
    output logic               sub_pulse_o,
    output logic               read_en_o,
    output logic               busy_o,
    output logic               err_o
);

    logic [LINE_W-1:0] line_nxt, line_q, lc_nxt;
    logic read_go, timed_nxt, expose_nxt, final_nxt, hold_q;
    logic read_q, arm_q, fire, sweep, forced;

    shut_line_ctr u_line (
        .clk        (clk),
        .rst        (rst),
        .vsync_i    (vsync_i),
        .hsync_i    (hsync_i),
        .line_nxt_o (line_nxt),
        .line_q_o   (line_q)
    );

    shut_field_ctl #(.LINE_MAX(LINE_MAX), .MON_MIN(MON_MIN)) u_field (
        .clk          (clk),
        .rst          (rst),
        .vsync_i      (vsync_i),
        .rec_i        (rec_mode_i),
        .mode_i       (shut_mode_i),
        .frames_i     (frame_cnt_i),
        .lines_i      (line_cnt_i),
        .expose_i     (expose_i),
        .read_go_o    (read_go),
        .timed_nxt_o  (timed_nxt),
        .expose_nxt_o (expose_nxt),
        .final_nxt_o  (final_nxt),
        .lc_nxt_o     (lc_nxt),
        .hold_q_o     (hold_q),
        .busy_o       (busy_o),
        .err_o        (err_o)
    );

    assign sweep  = (vsync_i || hsync_i) && timed_nxt && final_nxt && (line_nxt <= lc_nxt);
    assign forced = hsync_i && !vsync_i && arm_q && (line_nxt == LINE_W'(1));
    assign fire   = sweep || forced;

    always_ff @(posedge clk) begin
        if (rst) begin
            read_q <= 1'b0;
            arm_q  <= 1'b0;
        end else if (vsync_i) begin
            read_q <= read_go;
            arm_q  <= read_go && expose_nxt;
        end else if (hsync_i) begin
            read_q <= 1'b0;
            arm_q  <= 1'b0;
        end
    end

    shut_sub_gen #(.SUB_W(SUB_W)) u_sub (
        .clk    (clk),
        .rst    (rst),
        .fire_i (fire),
        .sub_o  (sub_pulse_o)
    );

    assign read_en_o = read_q;

    // R10: readout enable is confined to line 0
    a_r10_read_line0: assert property (@(posedge clk) disable iff (rst)
        read_q |-> (line_q == '0));

    // R10: a horizontal strobe ends the readout line
    a_r10_read_ends: assert property (@(posedge clk) disable iff (rst)
        (hsync_i && !vsync_i) |=> !read_q);

    // R6: a field under the hold mode closes without readout
    a_r6_hold_no_read: assert property (@(posedge clk) disable iff (rst)
        (vsync_i && hold_q) |=> !read_q);

    // R4: no readout while fields remain to be counted
    a_r4_busy_no_read: assert property (@(posedge clk) disable iff (rst)
        (vsync_i && busy_o) |=> !read_q);

endmodule

// File: tb/ccd_shutter_seq_tb_top.sv
module ccd_shutter_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LMAX = 12;
    localparam int LMIN = 6;
    localparam int SW   = 3;
    localparam int HP   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vsync = 1'b0, hsync = 1'b0, rec = 1'b0, expose = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [7:0] frames = '0;
    logic [9:0] lines = '0;
    logic sub_p, rd, busy, err;

    int checks = 0;
    int fails  = 0;
    int sub_cyc [0:LMAX];
    int rd_cyc  [0:LMAX];
    logic busy_s;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccd_shutter_seq #(.LINE_MAX(LMAX), .MON_MIN(LMIN), .SUB_W(SW)) dut_i (
        .clk(clk), .rst(rst), .vsync_i(vsync), .hsync_i(hsync),
        .rec_mode_i(rec), .shut_mode_i(mode), .frame_cnt_i(frames),
        .line_cnt_i(lines), .expose_i(expose),
        .sub_pulse_o(sub_p), .read_en_o(rd), .busy_o(busy), .err_o(err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic run_field();
        for (int n = 0; n <= LMAX; n++) begin
            @(negedge clk);
            if (n == 0) vsync = 1'b1; else hsync = 1'b1;
            sub_cyc[n] = 0;
            rd_cyc[n]  = 0;
            for (int j = 0; j < HP; j++) begin
                @(negedge clk);
                if (j == 0) begin
                    vsync = 1'b0; hsync = 1'b0;
                    if (n == 0) busy_s = busy;
                end
                if (sub_p) sub_cyc[n]++;
                if (rd)    rd_cyc[n]++;
            end
        end
    endtask

    task automatic expect_field(input string req, input bit er, input int upto,
                                input bit ex, input bit eb);
        int bad_s, bad_r;
        bad_s = -1; bad_r = -1;
        for (int n = 0; n <= LMAX; n++) begin
            int es, erd;
            es  = ((n <= upto) || (n == 1 && ex)) ? SW : 0;
            erd = (n == 0 && er) ? HP : 0;
            if (sub_cyc[n] != es && bad_s < 0) bad_s = n;
            if (rd_cyc[n] != erd && bad_r < 0) bad_r = n;
        end
        if (bad_s >= 0)
            chk(req, $sformatf("sub cycles line %0d", bad_s), sub_cyc[bad_s],
                ((bad_s <= upto) || (bad_s == 1 && ex)) ? SW : 0);
        else chk(req, "sub pattern", 0, 0);
        if (bad_r >= 0)
            chk(req, $sformatf("read cycles line %0d", bad_r), rd_cyc[bad_r],
                (bad_r == 0 && er) ? HP : 0);
        else chk(req, "read pattern", 0, 0);
        chk(req, "busy", int'(busy_s), int'(eb));
    endtask

    task automatic set_in(input logic [1:0] m, input int f, input int l,
                          input bit r, input bit e);
        mode = m; frames = 8'(f); lines = 10'(l); rec = r; expose = e;
    endtask

    initial begin
        bit errm;
        do_reset();
        @(negedge clk);
        // R1: reset state
        chk("R1", "sub_pulse", int'(sub_p), 0);
        chk("R1", "read_en", int'(rd), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "err", int'(err), 0);

        // R3: off modes, frame count ignored
        set_in(2'b00, 4, 2, 1, 0); run_field(); expect_field("R3 R1", 1, -1, 0, 0);
        set_in(2'b10, 4, 2, 1, 0); run_field(); expect_field("R3", 1, -1, 0, 0);

        // R2 R8 R9 R10 R11: recording sweep of every line count
        errm = 0;
        for (int lc = 0; lc < 16; lc++) begin
            int up;
            up = (lc > LMAX) ? LMAX : lc;
            errm |= (lc > LMAX);
            set_in(2'b01, 0, lc, 1, 0); run_field();
            expect_field("R2 R8 R9 R10 R11", 1, up, 0, 0);
            chk("R8 R9", "err", int'(err), int'(errm));
        end

        // R9 R8: monitoring sweep
        do_reset();
        errm = 0;
        for (int lc = 0; lc < 16; lc++) begin
            int up;
            up = (lc < LMIN) ? LMIN : (lc > LMAX) ? LMAX : lc;
            errm |= (lc < LMIN) || (lc > LMAX);
            set_in(2'b01, 0, lc, 0, 0); run_field();
            expect_field("R9 R2", 1, up, 0, 0);
            chk("R9 R8", "err", int'(err), int'(errm));
        end

        // R4 R5: long exposure with frozen settings
        do_reset();
        set_in(2'b01, 2, 5, 1, 0); run_field(); expect_field("R4", 1, -1, 0, 1);
        set_in(2'b00, 7, 9, 1, 1); run_field(); expect_field("R4 R5", 0, -1, 0, 1);
        run_field(); expect_field("R4 R5", 0, 5, 0, 0);
        run_field(); expect_field("R4 R3", 1, -1, 1, 0);
        chk("R5", "err", int'(err), 0);

        // R6: hold mode
        set_in(2'b11, 5, 3, 1, 0); run_field(); expect_field("R6", 1, -1, 0, 0);
        run_field(); expect_field("R6", 0, -1, 0, 0);
        set_in(2'b01, 0, 4, 1, 0); run_field(); expect_field("R6", 0, 4, 0, 0);
        run_field(); expect_field("R6 R2", 1, 4, 0, 0);

        // R7: forced pulse after readout
        set_in(2'b00, 0, 4, 1, 1); run_field(); expect_field("R7", 1, -1, 1, 0);
        set_in(2'b01, 0, 0, 1, 1); run_field(); expect_field("R7", 1, 0, 1, 0);
        set_in(2'b11, 0, 0, 1, 1); run_field(); expect_field("R7", 1, -1, 1, 0);
        run_field(); expect_field("R7 R6", 0, -1, 0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule